// File: doc/BRIEF.md
# I2C Bus-Recovery Clock Pulse Generator

This block sits next to an I2C master controller and produces one additional SCL clock pulse each time software sets a request bit. It is used when a slave has lost bit alignment with the master and keeps SDA pulled low. In that state the master cannot place a stop condition on the bus. Software issues pulses one at a time and watches the SDA level readback after each. Once the slave lets go of SDA, software hands control back to the master so that it can send a fresh stop condition.

Each pulse uses the same programmable low-period and high-period counts as the normal bit rate. The request bit stays at 1 while the pulse is in progress and drops by itself when the pulse ends. A request is only taken when two conditions hold: the bus is free, or it is busy with this side as master; and no device is holding SCL low at that moment. During the high phase, a slave that stretches the clock delays the end of the pulse. An optional check reports arbitration loss when SDA reads low while this side is releasing it.

Top module: `scl_recover`

## Requirements
- R1: After reset the request bit reads 0 and both drive enables (scl_oe, sda_oe) are 0. A drive enable of 1 pulls its line low.
- R2: An accepted request holds scl_oe at 1 for exactly low_cnt consecutive cycles, starting in the cycle after the write edge. A count of 0 acts as 1.
- R3: After the low phase, scl_oe is 0 and the request bit stays 1 until high_cnt cycles have been seen with scl_in at 1. A count of 0 acts as 1. The request bit then reads 0.
- R4: Each accepted request gives exactly one low pulse on scl_oe. After the request bit clears, scl_oe stays 0 until the next accepted request.
- R5: When bus_busy is 1 and master_mode is 0, a request is ignored. The request bit reads 0 in the next cycle and scl_oe stays 0. A request is taken when bus_busy is 0 (whatever master_mode is) or when both are 1.
- R6: A request made while scl_in is 0 is ignored. The request bit reads 0 in the next cycle and no pulse follows.
- R7: During the high phase, cycles in which scl_in is 0 do not count toward high_cnt. Clock stretching therefore lengthens the request time by exactly the number of stretched cycles.
- R8: sda_level shows the value that sda_in had one cycle earlier, at all times.
- R9: arb_lost is 1 in the cycle after one in which arb_en is 1 and sda_in is 0, and 0 otherwise. The block's own SDA drive value is always the released level, 1.
- R10: sda_oe stays 0 at all times, so SDA is released during every recovery pulse.
- R11: A request write that arrives while a pulse is in progress is ignored. It neither shortens nor extends that pulse, and it adds no second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 1 | One-cycle write of 1 to the request bit |
| low_cnt | input | CNT_W | SCL low-phase length in cycles |
| high_cnt | input | CNT_W | SCL high-phase length in cycles |
| bus_busy | input | 1 | Bus busy flag |
| master_mode | input | 1 | This side is master |
| arb_en | input | 1 | Enable for the arbitration-loss check |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| req_o | output | 1 | Request bit readback |
| scl_oe | output | 1 | SCL pull-low enable |
| sda_oe | output | 1 | SDA pull-low enable |
| sda_level | output | 1 | SDA level readback |
| arb_lost | output | 1 | Arbitration-loss indication |

## Verification
The bench targets low and high counts of zero, one and the largest value the counter holds. A design that failed to clamp a zero count would wrap the counter and produce a pulse hundreds of cycles long. Every combination of busy and master flags is tried, together with requests made while another device holds SCL low. A design that qualified requests wrongly would start a pulse on a bus it does not own, or refuse one on a free bus. The bench also writes the request bit again during a pulse and stretches the high phase. A design that queued the extra write, or counted stretched cycles, would show a second pulse or clear the request bit too early.

// File: rtl/scl_recover.sv
module scl_recover #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_set,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             bus_busy,
  input  logic             master_mode,
  input  logic             arb_en,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             req_o,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             sda_level,
  output logic             arb_lost
);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low_lim, high_lim, lim;
  logic [CNT_W:0]   cnt_inc;
  logic             phase_done, bus_ok, accept;

  assign low_lim    = (low_cnt  == '0) ? CNT_W'(1) : low_cnt;
  assign high_lim   = (high_cnt == '0) ? CNT_W'(1) : high_cnt;
  assign lim        = (state == S_LOW) ? low_lim : high_lim;
  assign cnt_inc    = {1'b0, cnt} + 1'b1;
  assign phase_done = cnt_inc >= {1'b0, lim};

  assign bus_ok = !bus_busy || master_mode;
  assign accept = (state == S_IDLE) && req_set && bus_ok && scl_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_LOW;
          cnt   <= '0;
        end
        S_LOW: begin
          if (phase_done) begin
            state <= S_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt_inc[CNT_W-1:0];
          end
        end
        S_HIGH: if (scl_in) begin
          if (phase_done) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt_inc[CNT_W-1:0];
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_level <= 1'b1;
      arb_lost  <= 1'b0;
    end else begin
      sda_level <= sda_in;
      arb_lost  <= arb_en && !sda_in;
    end
  end

  assign req_o  = (state != S_IDLE);
  assign scl_oe = (state == S_LOW);
  assign sda_oe = 1'b0;

endmodule

// File: rtl/scl_recover_chk.sv
module scl_recover_chk (
  input logic clk,
  input logic rst_n,
  input logic req_set,
  input logic bus_busy,
  input logic master_mode,
  input logic scl_in,
  input logic req_o,
  input logic scl_oe
);

  // R2
  pulse_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> req_o);

  // R3
  end_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(scl_in) && !scl_oe);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !scl_oe |=> !scl_oe);

  // R5
  not_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o && req_set && bus_busy && !master_mode |=> !req_o);

  // R6
  scl_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o && req_set && !scl_in |=> !req_o);

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !scl_oe && !scl_in |=> req_o);

endmodule

bind scl_recover scl_recover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_set(req_set), .bus_busy(bus_busy),
  .master_mode(master_mode), .scl_in(scl_in), .req_o(req_o), .scl_oe(scl_oe)
);

// File: tb/scl_recover_tb.sv
`timescale 1ns/1ps
module scl_recover_tb;
  localparam int CNT_W = 8;

  logic clk = 0, rst_n = 0, req_set = 0;
  logic [CNT_W-1:0] low_cnt = 0, high_cnt = 0;
  logic bus_busy = 0, master_mode = 0, arb_en = 0, sda_in = 1, ext_low = 0;
  logic scl_in, req_o, scl_oe, sda_oe, sda_level, arb_lost;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign scl_in = !(scl_oe || ext_low);

  scl_recover #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .bus_busy(bus_busy), .master_mode(master_mode),
    .arb_en(arb_en), .scl_in(scl_in), .sda_in(sda_in), .req_o(req_o),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_level(sda_level), .arb_lost(arb_lost));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit qualifies(input bit busy, input bit mst, input bit held);
    return (!busy || mst) && !held;
  endfunction

  task automatic pulse(input int l, input int h, input int stretch, input bit busy,
                       input bit mst, input bit held, input bit rewrite);
    int lc, hc, extra;
    bit acc;
    acc = qualifies(busy, mst, held);
    @(negedge clk);
    low_cnt = l[CNT_W-1:0]; high_cnt = h[CNT_W-1:0];
    bus_busy = busy; master_mode = mst; ext_low = held; req_set = 1;
    @(negedge clk);
    req_set = 0; ext_low = 0;
    if (!acc) begin
      chk(req_o == 0, held ? "R6 reject held scl" : "R5 reject not owner", req_o, 0);
      extra = 0;
      repeat (4) begin @(negedge clk); extra += scl_oe; end
      chk(extra == 0, held ? "R6 no pulse" : "R5 no pulse", extra, 0);
      return;
    end
    lc = 0;
    while (scl_oe && lc < 1000) begin
      req_set = (rewrite && lc == 0);
      chk(req_o == 1, "R2 request set during low", req_o, 1);
      lc++;
      @(negedge clk);
    end
    req_set = 0;
    chk(lc == eff(l), rewrite ? "R11 low length with rewrite" : "R2 low length", lc, eff(l));
    hc = 0; extra = 0;
    while (req_o && hc < 2000) begin
      ext_low = (hc < stretch);
      extra += scl_oe;
      hc++;
      @(negedge clk);
    end
    ext_low = 0;
    chk(hc == eff(h) + stretch, stretch > 0 ? "R7 stretched high" : "R3 high length",
        hc, eff(h) + stretch);
    chk(extra == 0, "R4 no drive in high phase", extra, 0);
    extra = 0;
    repeat (3) begin extra += scl_oe + req_o; @(negedge clk); end
    chk(extra == 0, rewrite ? "R11 no second pulse" : "R4 self-clear idle", extra, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit pa, pe;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk(req_o == 0 && scl_oe == 0 && sda_oe == 0, "R1 reset state",
        {req_o, scl_oe, sda_oe}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_o == 0 && scl_oe == 0, "R1 idle after reset", {req_o, scl_oe}, 0);

    pulse(0, 0, 0, 0, 0, 0, 0);
    pulse(1, 1, 0, 1, 1, 0, 0);
    pulse(255, 255, 0, 0, 1, 0, 0);
    pulse(3, 4, 5, 1, 1, 0, 0);
    pulse(4, 2, 0, 1, 0, 0, 0);
    pulse(4, 2, 0, 0, 0, 1, 0);
    pulse(5, 3, 0, 0, 0, 0, 1);

    for (int i = 0; i < 40; i++)
      pulse($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 4),
            $urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 3) == 0));

    @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      pa = arb_en; pe = sda_in;
      arb_en = $urandom_range(0, 1); sda_in = $urandom_range(0, 1);
      pa = arb_en; pe = sda_in;
      @(negedge clk);
      chk(sda_level == pe, "R8 sda readback", sda_level, pe);
      chk(arb_lost == (pa && !pe), "R9 arbitration check", arb_lost, pa && !pe);
      chk(sda_oe == 0, "R10 sda released", sda_oe, 0);
    end
    sda_in = 1; arb_en = 0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule